// File: doc/BRIEF.md
# Tag Store with Built-in Equality Comparator

This block holds one narrow slice of a cache tag. It stores 4096 words of 4 bits each and compares the word at the given address with the tag nibble on the data input. A cycle with write enable high stores the input nibble. Any other cycle, outside a clear, is a lookup. The outcome of a lookup appears on an active-high `match` output one clock later. A cascade input is ANDed into the result, so several slices can be chained to form a wider tag match. Readback uses a separate, zero-gated data output rather than a shared bus.

The clear request wipes the whole array to zero. It does this with a sequential sweep that writes one word per clock and raises a busy flag while it runs. Reset starts the same sweep, so the contents are known once the flag drops. The array uses a single synchronous read/write port, so it maps onto one block RAM.

Top module: `tagcmp_store`

## Requirements
- R1: A cycle with `we`=1, `clr`=0 and `clr_busy`=0 stores `din` into the word at `addr` on that clock edge.
- R2: After a cycle with `we`=0, `clr`=0, `clr_busy`=0 and `match_in`=1, `match` is 1 during the next cycle exactly when the addressed word equals that cycle's `din`, and 0 otherwise.
- R3: After any cycle with `match_in`=0, `match` is 0 during the next cycle.
- R4: After any cycle with `we`=1, `match` is 0 during the next cycle, even when the stored word equals `din`.
- R5: After a cycle with `clr`=1 and `clr_busy`=0, `clr_busy` reads 1 for exactly 4096 consecutive cycles, starting with the next cycle. Every word then reads zero.
- R6: While a clear runs, including the cycle in which `clr` is raised, lookups give `match`=0 in the following cycle and writes are discarded.
- R7: After a cycle with `oe`=1, `we`=0 and `clr_busy`=0, `rdata` shows the addressed word during the next cycle. After any other cycle, `rdata` is 0.
- R8: Reset holds `match` and `rdata` at 0 and starts a clear. On release, `clr_busy` reads 1.
- R9: A lookup in the cycle right after a write to the same address compares against the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Word select |
| din | input | 4 | Tag nibble to write or compare |
| we | input | 1 | Write enable; low means lookup |
| oe | input | 1 | Readback enable |
| clr | input | 1 | Request a whole-array clear |
| match_in | input | 1 | Cascade input from the preceding slice |
| match | output | 1 | Lookup result, one clock after the request |
| rdata | output | 4 | Readback word, zero when not enabled |
| clr_busy | output | 1 | Clear sweep in progress |

## Verification
The assertions assume the control inputs are known on every clock edge after reset. They also assume `clr` is only raised when the surrounding logic means it as a one-cycle request. Nothing else about the inputs is constrained, so writes, lookups and readback may be mixed freely.

The stimulus drives every input on the falling edge and holds it for exactly one rising edge. It issues `clr` as a single-cycle pulse. It waits for `clr_busy` to drop before making any check that depends on the array contents. The only exception is the deliberate lookups and writes issued during a sweep, which exercise R6.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;

  // Per-cycle qualifiers carried alongside the array read
  typedef struct packed {
    logic cmp_ok;   // cycle was a legal lookup
    logic cas_in;   // cascade input sampled with it
    logic rd_ok;    // readback enabled for this cycle
  } tagcmp_qual_t;

endpackage

// File: rtl/tagcmp_array.sv
module tagcmp_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-first, synchronous read: maps to block RAM
  always_ff @(posedge clk) begin
    if (wen) mem[addr] <= wdata;
    rd_q <= mem[addr];
  end
endmodule

// File: rtl/tagcmp_sweep.sv
module tagcmp_sweep #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == '1) busy <= 1'b0;
      ptr <= ptr + 1'b1;
    end else if (clr_req) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  // R5
  sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(ptr) == '1);

  // R5
  sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/tagcmp_result.sv
module tagcmp_result
  import tagcmp_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter bit USE_CASCADE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  tagcmp_qual_t      qual,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_q,
  output logic              match,
  output logic [DATA_W-1:0] rdata
);
  tagcmp_qual_t      qual_q;
  logic [DATA_W-1:0] din_q;
  logic              cas_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= '0;
      din_q  <= '0;
    end else begin
      qual_q <= qual;
      din_q  <= din;
    end
  end

  generate
    if (USE_CASCADE) begin : g_cascade
      assign cas_ok = qual_q.cas_in;
    end else begin : g_standalone
      assign cas_ok = 1'b1;
    end
  endgenerate

  assign match = qual_q.cmp_ok && cas_ok && (rd_q == din_q);
  assign rdata = qual_q.rd_ok ? rd_q : '0;

  generate
    if (USE_CASCADE) begin : g_cas_chk
      // R3
      cascade_block_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(qual.cas_in) |-> !match);
    end
  endgenerate

  // R7
  rdata_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(qual.rd_ok) |-> rdata == '0);
endmodule

// File: rtl/tagcmp_store.sv
module tagcmp_store
  import tagcmp_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 4,
  parameter bit USE_CASCADE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              we,
  input  logic              oe,
  input  logic              clr,
  input  logic              match_in,
  output logic              match,
  output logic [DATA_W-1:0] rdata,
  output logic              clr_busy
);
  logic [ADDR_W-1:0] sweep_ptr;
  logic              write_ok;
  logic              arr_wen;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;
  logic [DATA_W-1:0] arr_rd;
  tagcmp_qual_t      qual;

  tagcmp_sweep #(.ADDR_W(ADDR_W)) sweep_i (
    .clk(clk), .rst(rst), .clr_req(clr), .busy(clr_busy), .ptr(sweep_ptr)
  );

  // clear sweep owns the port; a write in the request cycle is dropped
  assign write_ok  = we && !clr && !clr_busy;
  assign arr_wen   = clr_busy || write_ok;
  assign arr_addr  = clr_busy ? sweep_ptr : addr;
  assign arr_wdata = clr_busy ? '0 : din;

  tagcmp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .wen(arr_wen), .addr(arr_addr), .wdata(arr_wdata), .rd_q(arr_rd)
  );

  always_comb begin
    qual.cmp_ok = !we && !clr && !clr_busy;
    qual.cas_in = match_in;
    qual.rd_ok  = oe && !we && !clr_busy;
  end

  tagcmp_result #(.DATA_W(DATA_W), .USE_CASCADE(USE_CASCADE)) result_i (
    .clk(clk), .rst(rst), .qual(qual), .din(din), .rd_q(arr_rd),
    .match(match), .rdata(rdata)
  );

  // R4
  write_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    $past(we) |-> !match);

  // R6
  clear_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_busy) || $past(clr)) |-> !match);

  // R5
  clear_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !$past(clr_busy)) |-> clr_busy);
endmodule

// File: tb/tagcmp_store_tb_top.sv
module tagcmp_store_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic              we = 1'b0, oe = 1'b0, clr = 1'b0, match_in = 1'b1;
  logic              match;
  logic [DATA_W-1:0] rdata;
  logic              clr_busy;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tagcmp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .USE_CASCADE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .we(we), .oe(oe),
    .clr(clr), .match_in(match_in), .match(match), .rdata(rdata),
    .clr_busy(clr_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with the given inputs; returns at the following falling edge
  task automatic cyc(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                     input logic w, input logic o, input logic c, input logic m);
    addr = a; din = d; we = w; oe = o; clr = c; match_in = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_clear();
    while (clr_busy) cyc('0, '0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    repeat (3) cyc('0, '0, 0, 0, 0, 1);
    rst = 1'b0;
    chk(clr_busy == 1'b1, "R8 busy", clr_busy, 1);
    chk(match == 1'b0, "R8 match", match, 0);
    chk(rdata == '0, "R8 rdata", rdata, 0);
    wait_clear();
    cyc(12'h123, 4'h0, 0, 1, 0, 1);
    chk(match == 1'b1, "R8 cleared word", match, 1);
  endtask

  task automatic t_write_compare();
    cyc(12'h010, 4'hA, 1, 0, 0, 1);
    chk(match == 1'b0, "R4 write cycle", match, 0);
    cyc(12'h010, 4'hA, 0, 0, 0, 1);
    chk(match == 1'b1, "R9 compare after write", match, 1);
    cyc(12'hFFF, 4'h5, 1, 0, 0, 1);
    cyc(12'h010, 4'hA, 0, 0, 0, 1);
    chk(match == 1'b1, "R1 word kept", match, 1);
    cyc(12'hFFF, 4'h5, 0, 0, 0, 1);
    chk(match == 1'b1, "R2 top address hit", match, 1);
    cyc(12'h010, 4'hB, 0, 0, 0, 1);
    chk(match == 1'b0, "R2 mismatch", match, 0);
    cyc(12'h011, 4'hA, 0, 0, 0, 1);
    chk(match == 1'b0, "R2 other address", match, 0);
  endtask

  task automatic t_cascade();
    cyc(12'h010, 4'hA, 0, 0, 0, 0);
    chk(match == 1'b0, "R3 cascade low", match, 0);
    cyc(12'h010, 4'hA, 0, 0, 0, 1);
    chk(match == 1'b1, "R3 cascade high", match, 1);
  endtask

  task automatic t_write_priority();
    cyc(12'h010, 4'hA, 1, 0, 0, 1);
    chk(match == 1'b0, "R4 equal data write", match, 0);
    cyc(12'h010, 4'h3, 1, 1, 0, 1);
    chk(rdata == '0, "R7 rdata during write", rdata, 0);
    cyc(12'h010, 4'h3, 0, 0, 0, 1);
    chk(match == 1'b1, "R9 overwrite", match, 1);
  endtask

  task automatic t_readback();
    cyc(12'hFFF, 4'h0, 0, 1, 0, 1);
    chk(rdata == 4'h5, "R7 readback", rdata, 5);
    cyc(12'h010, 4'h0, 0, 1, 0, 1);
    chk(rdata == 4'h3, "R7 readback second", rdata, 3);
    cyc(12'h010, 4'h0, 0, 0, 0, 1);
    chk(rdata == '0, "R7 oe low", rdata, 0);
  endtask

  task automatic t_clear();
    int n;
    cyc(12'h007, 4'h9, 1, 0, 0, 1);
    cyc(12'h008, 4'h6, 1, 0, 1, 1);
    chk(clr_busy == 1'b1, "R5 busy after request", clr_busy, 1);
    chk(match == 1'b0, "R6 request cycle", match, 0);
    n = 1;
    cyc(12'h010, 4'h0, 0, 0, 0, 1);
    chk(match == 1'b0, "R6 lookup during clear", match, 0);
    if (clr_busy) n++;
    cyc(12'h007, 4'hF, 1, 0, 0, 1);
    if (clr_busy) n++;
    while (clr_busy) begin
      cyc('0, '0, 0, 0, 0, 1);
      if (clr_busy) n++;
    end
    chk(n == DEPTH, "R5 busy length", n, DEPTH);
    cyc(12'h007, 4'h0, 0, 1, 0, 1);
    chk(match == 1'b1 && rdata == '0, "R6 write discarded", rdata, 0);
    cyc(12'h008, 4'h0, 0, 1, 0, 1);
    chk(rdata == '0, "R6 request write discarded", rdata, 0);
    cyc(12'hFFF, 4'h0, 0, 0, 0, 1);
    chk(match == 1'b1, "R5 word zeroed", match, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_compare();
        t_cascade();
        t_write_priority();
        t_readback();
        t_clear();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule